// File: doc/BRIEF.md
# Prescaled PWM Channel Core

This block produces one pulse-width-modulated output from a system clock. A prescaler divides the clock into count ticks. A period counter steps once per tick from zero up to a programmed terminal value and then wraps to zero. The output is active while the count is below a duty value. A polarity control can invert the output, and a single-cycle pulse marks each period boundary.

Prescale, period and duty values are written into shadow registers. They reach the working registers in one of three ways: at a period boundary when autoload is set, at any time while the channel is disabled when autoload is set, or at once through two force-load controls, one for prescale and one for period. Disabling the channel either halts it at once or lets the current period finish first.

Sequencing is done by a three-state machine. `ST_IDLE` means the channel is disabled, with both counters held at zero. `ST_RUN` means it is counting. `ST_DRAIN` means the channel has been disabled and is finishing its current period. The transitions are as follows:
- *start*: `ST_IDLE` to `ST_RUN` on enable.
- *halt*: `ST_RUN` to `ST_IDLE` on disable with stop-immediately set.
- *drain*: `ST_RUN` to `ST_DRAIN` on disable with stop-immediately clear.
- *resume*: `ST_DRAIN` to `ST_RUN` on enable.
- *finish*: `ST_DRAIN` to `ST_IDLE` at the period wrap.

Top module: `pwm_channel_core`

## Requirements
- R1: After reset, `pwm_out` and `period_end` are 0, and the shadow and working prescale, period and duty values are all 0.
- R2: While running, the period counter advances once every (prescale+1) clocks. One period lasts (period+1)×(prescale+1) clocks. `period_end` is high for exactly the one clock cycle at whose end the counter wraps from its terminal value to 0, and is never high while disabled.
- R3: Before inversion, the output is active (1) while the count is below the working duty. A duty of 0 keeps the output inactive for the whole period. A duty above the working period keeps it active for the whole period.
- R4: `pwm_out` is the active level XOR `ctl_invert`, and `ctl_invert` acts combinationally. While in `ST_IDLE`, `pwm_out` equals `ctl_invert`.
- R5: A clock with `cfg_wr`=1 captures all three inputs into the shadow registers. With `ctl_autoload`=1, the shadows are copied into the working registers at the clock edge that ends a period, and on every clock while in `ST_IDLE`. A new duty therefore first shows in the period after the write.
- R6: With `ctl_autoload`=0 and no force-load asserted, shadow contents have no effect on the waveform.
- R7: Each clock with `ctl_force_prescale`=1 copies the shadow prescale into the working prescale. Each clock with `ctl_force_period`=1 does the same for the period. Neither needs autoload.
- R8: In `ST_RUN` with `ctl_enable`=0 and `ctl_stop_now`=1, the next clock enters `ST_IDLE` with both counters at 0. A later enable starts again from count 0.
- R9: In `ST_RUN` with `ctl_enable`=0 and `ctl_stop_now`=0, the channel completes the current period unchanged, then enters `ST_IDLE` at the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Capture the three config inputs into the shadow registers |
| cfg_prescale | input | 10 | Prescale value; tick every value+1 clocks |
| cfg_period | input | 12 | Terminal count of the period counter |
| cfg_duty | input | 12 | Compare value for the active phase |
| ctl_enable | input | 1 | Channel enable |
| ctl_invert | input | 1 | Output polarity inversion |
| ctl_autoload | input | 1 | Copy shadows to working registers at period boundaries |
| ctl_stop_now | input | 1 | On disable, halt at once instead of finishing the period |
| ctl_force_prescale | input | 1 | Copy shadow prescale to working register now |
| ctl_force_period | input | 1 | Copy shadow period to working register now |
| pwm_out | output | 1 | PWM waveform |
| period_end | output | 1 | One-cycle pulse in the last clock of each period |

## Verification
The assertions check several properties on every cycle:
- the counter holds between ticks and returns to zero after every wrap;
- `period_end` appears only while live;
- the idle output level follows the polarity input;
- a duty of zero keeps the output inactive;
- the working period is left untouched when no load is requested;
- the halt and drain transitions land in the state the requirements name.

Only the directed scenarios can show the rest:
- exact period length and duty count for several prescale and period pairs;
- that an autoloaded duty waits for the next boundary;
- that force-loads act mid-run;
- that a halted channel restarts from count zero while a drained one stops exactly at its wrap.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    // Channel sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } chan_state_t;

endpackage

// File: rtl/pwm_cfg_bank.sv
// Shadow and working copies of prescale, period and duty.
module pwm_cfg_bank #(
    parameter int PRE_W = 10,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PRE_W-1:0] wr_prescale,
    input  logic [PER_W-1:0] wr_period,
    input  logic [PER_W-1:0] wr_duty,
    input  logic             load_all,
    input  logic             force_prescale,
    input  logic             force_period,
    output logic [PRE_W-1:0] act_prescale,
    output logic [PER_W-1:0] act_period,
    output logic [PER_W-1:0] act_duty
);

    logic [PRE_W-1:0] sh_prescale;
    logic [PER_W-1:0] sh_period;
    logic [PER_W-1:0] sh_duty;

    // Shadow capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_prescale <= '0;
            sh_period   <= '0;
            sh_duty     <= '0;
        end else if (wr_en) begin
            sh_prescale <= wr_prescale;
            sh_period   <= wr_period;
            sh_duty     <= wr_duty;
        end
    end

    // Working copies: boundary/idle load or forced load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_prescale <= '0;
            act_period   <= '0;
            act_duty     <= '0;
        end else begin
            if (load_all || force_prescale) act_prescale <= sh_prescale;
            if (load_all || force_period)   act_period   <= sh_period;
            if (load_all)                   act_duty     <= sh_duty;
        end
    end

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_all && !force_period) |=> $stable(act_period)); // R6

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_all |=> $stable(act_duty)); // R6

endmodule

// File: rtl/pwm_prescaler.sv
// Divides the clock into count ticks, one every limit+1 clocks.
module pwm_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);

    logic [PRE_W-1:0] div_cnt;

    // A limit lowered below the current count still ticks at once.
    assign tick = count_en && (div_cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        div_cnt <= '0;
        else if (!count_en) div_cnt <= '0;
        else if (tick)      div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (div_cnt == '0)); // R2

endmodule

// File: rtl/pwm_period_counter.sv
// Counts ticks from 0 to the terminal value, then wraps.
module pwm_period_counter #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             tick,
    input  logic [PER_W-1:0] terminal,
    output logic [PER_W-1:0] cnt,
    output logic             wrap
);

    // Greater-or-equal tolerates a terminal forced below the count.
    assign wrap = count_en && tick && (cnt >= terminal);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (!count_en) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !tick) |=> $stable(cnt)); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R2

endmodule

// File: rtl/pwm_run_fsm.sv
// Enable / halt / drain sequencing of the channel.
module pwm_run_fsm
    import pwm_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        stop_now,
    input  logic        autoload,
    input  logic        wrap,
    output chan_state_t state,
    output logic        live,
    output logic        count_en,
    output logic        load_all
);

    chan_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (enable) state_nxt = ST_RUN;                   // start
            ST_RUN:   if (!enable)
                          state_nxt = stop_now ? ST_IDLE : ST_DRAIN;    // halt / drain
            ST_DRAIN: if (enable)    state_nxt = ST_RUN;                // resume
                      else if (wrap) state_nxt = ST_IDLE;               // finish
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Outputs
    always_comb begin
        live     = (state != ST_IDLE);
        // Counters clear in the same edge as a halt.
        count_en = live && !(state == ST_RUN && !enable && stop_now);
        load_all = autoload && ((state == ST_IDLE) || wrap);
    end

    AST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !enable && stop_now) |=> (state == ST_IDLE)); // R8

    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !enable && wrap) |=> (state == ST_IDLE)); // R9

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !enable && !wrap) |=> (state == ST_DRAIN)); // R9

endmodule

// File: rtl/pwm_channel_core.sv
module pwm_channel_core
    import pwm_chan_pkg::*;
#(
    parameter int PRE_W = 10,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [PER_W-1:0] cfg_duty,
    input  logic             ctl_enable,
    input  logic             ctl_invert,
    input  logic             ctl_autoload,
    input  logic             ctl_stop_now,
    input  logic             ctl_force_prescale,
    input  logic             ctl_force_period,
    output logic             pwm_out,
    output logic             period_end
);

    logic [PRE_W-1:0] act_prescale;
    logic [PER_W-1:0] act_period;
    logic [PER_W-1:0] act_duty;
    logic [PER_W-1:0] cnt;
    logic             tick;
    logic             wrap;
    logic             live;
    logic             count_en;
    logic             load_all;
    logic             raw_active;
    chan_state_t      state;

    pwm_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctl_enable),
        .stop_now (ctl_stop_now),
        .autoload (ctl_autoload),
        .wrap     (wrap),
        .state    (state),
        .live     (live),
        .count_en (count_en),
        .load_all (load_all)
    );

    pwm_cfg_bank #(.PRE_W(PRE_W), .PER_W(PER_W)) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (cfg_wr),
        .wr_prescale    (cfg_prescale),
        .wr_period      (cfg_period),
        .wr_duty        (cfg_duty),
        .load_all       (load_all),
        .force_prescale (ctl_force_prescale),
        .force_period   (ctl_force_period),
        .act_prescale   (act_prescale),
        .act_period     (act_period),
        .act_duty       (act_duty)
    );

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .limit    (act_prescale),
        .tick     (tick)
    );

    pwm_period_counter #(.PER_W(PER_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .tick     (tick),
        .terminal (act_period),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    // Outputs
    always_comb begin
        raw_active = live && (cnt < act_duty);
        pwm_out    = raw_active ^ ctl_invert;
        period_end = wrap;
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pwm_out == ctl_invert)); // R4

    AST_END_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> (state != ST_IDLE)); // R2

    AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty == '0) |-> (pwm_out == ctl_invert)); // R3

endmodule

// File: tb/tb_pwm_channel_core.sv
`timescale 1ns/1ps
module tb_pwm_channel_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [9:0]  cfg_prescale = '0;
    logic [11:0] cfg_period = '0;
    logic [11:0] cfg_duty = '0;
    logic        ctl_enable = 1'b0;
    logic        ctl_invert = 1'b0;
    logic        ctl_autoload = 1'b0;
    logic        ctl_stop_now = 1'b0;
    logic        ctl_force_prescale = 1'b0;
    logic        ctl_force_period = 1'b0;
    logic        pwm_out;
    logic        period_end;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_channel_core dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_prescale(cfg_prescale), .cfg_period(cfg_period), .cfg_duty(cfg_duty),
        .ctl_enable(ctl_enable), .ctl_invert(ctl_invert), .ctl_autoload(ctl_autoload),
        .ctl_stop_now(ctl_stop_now), .ctl_force_prescale(ctl_force_prescale),
        .ctl_force_period(ctl_force_period), .pwm_out(pwm_out), .period_end(period_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        cfg_wr = 1'b0;
    endtask

    task automatic write_cfg(input int pre, input int per, input int duty);
        cfg_prescale = pre[9:0];
        cfg_period   = per[11:0];
        cfg_duty     = duty[11:0];
        cfg_wr       = 1'b1;
    endtask

    // Sample n cycles; compare high count, end count and first end index.
    task automatic measure(input int n, input int exp_hi, input int exp_end,
                           input int exp_idx, input string req);
        int hi = 0;
        int ends = 0;
        int first = -1;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            if (period_end) begin
                ends++;
                if (first < 0) first = i;
            end
            step();
        end
        chk(hi == exp_hi, {req, " high cycles"}, hi, exp_hi);
        chk(ends == exp_end, {req, " period_end count"}, ends, exp_end);
        if (exp_idx >= -1) chk(first == exp_idx, {req, " period_end position"}, first, exp_idx);
    endtask

    // Align to the first cycle of a new period.
    task automatic sync_period();
        for (int i = 0; i < 5000; i++) begin
            if (period_end) begin
                step();
                return;
            end
            step();
        end
        chk(1'b0, "sync period_end", 0, 1);
    endtask

    task automatic t_reset();
        chk(pwm_out == 1'b0, "R1 pwm_out after reset", pwm_out, 0);
        chk(period_end == 1'b0, "R1 period_end after reset", period_end, 0);
        measure(8, 0, 0, -1, "R1 idle after reset");
    endtask

    task automatic t_basic();
        ctl_autoload = 1'b1;
        write_cfg(1, 4, 2);
        step();
        step();               // idle autoload copies shadows (R5)
        ctl_enable = 1'b1;
        step();               // now running at count 0
        measure(10, 4, 1, 9, "R2 R3 period one");
        measure(10, 4, 1, 9, "R2 R3 period two");
    endtask

    task automatic t_autoload();
        sync_period();
        write_cfg(1, 4, 0);
        measure(10, 4, 1, 9, "R5 old duty kept in current period");
        measure(10, 0, 1, 9, "R3 R5 duty zero next period");
        write_cfg(1, 4, 7);
        measure(10, 0, 1, 9, "R5 duty zero until boundary");
        measure(10, 10, 1, 9, "R3 duty above period always active");
    endtask

    task automatic t_no_autoload_force();
        ctl_autoload = 1'b0;
        write_cfg(1, 4, 0);
        measure(20, 20, 2, -2, "R6 shadow ignored");
        write_cfg(0, 9, 0);
        step();
        ctl_force_period = 1'b1;
        step();
        ctl_force_period = 1'b0;
        sync_period();
        measure(20, 14, 1, 19, "R7 forced period");
        ctl_force_prescale = 1'b1;
        step();
        ctl_force_prescale = 1'b0;
        sync_period();
        measure(10, 7, 1, 9, "R7 forced prescale");
    endtask

    task automatic t_invert();
        ctl_invert = 1'b1;
        sync_period();
        measure(10, 3, 1, 9, "R4 inverted waveform");
    endtask

    task automatic t_halt();
        step();
        step();
        ctl_enable   = 1'b0;
        ctl_stop_now = 1'b1;
        step();
        chk(pwm_out == 1'b1, "R4 R8 inverted idle level", pwm_out, 1);
        measure(30, 30, 0, -1, "R8 halted stays idle");
        ctl_invert = 1'b0;
        #1;
        chk(pwm_out == 1'b0, "R4 idle level follows invert", pwm_out, 0);
        ctl_stop_now = 1'b0;
        ctl_enable   = 1'b1;
        step();
        measure(10, 7, 1, 9, "R8 restart from count zero");
    endtask

    task automatic t_drain();
        sync_period();
        step();
        step();
        step();               // count 3
        ctl_enable   = 1'b0;
        ctl_stop_now = 1'b0;
        measure(7, 4, 1, 6, "R9 drain finishes period");
        measure(10, 0, 0, -1, "R9 idle after drain");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_autoload();
        t_no_autoload_force();
        t_invert();
        t_halt();
        t_drain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule